// File: doc/BRIEF.md
# Constant Reciprocal Divider

This block divides an unsigned operand by a divisor that is fixed when the design is elaborated. No iterative divider is built. The operand is multiplied by a reciprocal constant scaled by a power of two, and the top part of that product gives a first quotient estimate. A second stage rebuilds the remainder from that estimate. If the remainder is too large, the stage corrects the estimate once, so the quotient and remainder that come out are exact for every operand the input width can carry.

Results stream through a two-stage pipeline. A new operand can be accepted on every clock. A valid flag travels with each operand and comes out exactly two cycles later.

The reciprocal and its width are derived from the parameters. When the divisor is a power of two, the multiplier is left out and the estimate is a plain right shift.

Top module: `const_div_top`

## Requirements
- R1: While the active-low reset `rstN` is low, `validOut`, `quotient` and `remainder` are all zero, even if `validIn` is high.
- R2: For every operand accepted with `validIn` high, `quotient` equals floor(`dividend` / DIVISOR) in the cycle in which the matching `validOut` is high.
- R3: In that same cycle, `remainder` equals `dividend` mod DIVISOR, so it is always below DIVISOR.
- R4: `validOut` is high exactly when `validIn` was sampled high two rising edges earlier. Operands presented on consecutive cycles give results on consecutive cycles.
- R5: In cycles where `validOut` is low, `quotient` and `remainder` keep the last result. Any `dividend` presented with `validIn` low has no effect on them.
- R6: The reciprocal is floor(2^SHIFT / DIVISOR), which is 0x12492 for the defaults DIVISOR = 14 and SHIFT = 20. This constant makes the first estimate one short for some operands, for example every exact multiple of 14. For those operands the remainder check adds one to the quotient and subtracts DIVISOR from the remainder.
- R7: When DIVISOR is a power of two, the estimate is the operand shifted right by log2(DIVISOR), with no multiplier. The results still obey R2 to R4. For example, with DIVISOR = 8 the quotient is the operand shifted right by 3 and the remainder is its low 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Marks `dividend` as an operand to divide this cycle |
| dividend | input | DATA_W | Unsigned operand |
| validOut | output | 1 | Marks `quotient` and `remainder` as a new result |
| quotient | output | DATA_W | Exact integer quotient |
| remainder | output | REM_W | Exact remainder, where REM_W = max(1, clog2(DIVISOR)) |

## Verification
The situation that is hardest to reach is the correction step, where the multiply-and-shift estimate falls one short. With the default constant this happens only for particular operands, exact multiples of the divisor among them. Random stimulus seldom lands on such an operand while results are also streaming back to back.

The stimulus therefore sweeps every 14-bit operand on consecutive cycles, which hits every correction case. It then adds randomly gapped traffic and directed values at the top of the range and around the divisor. A second instance with a power-of-two divisor covers the shift-only variant.

// File: rtl/const_div_pkg.sv
package const_div_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEst;  // capture operand and first estimate
    logic loadRes;  // capture corrected quotient and remainder
  } divStrobe_t;

  function automatic bit isPow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int unsigned log2Exact(input int unsigned v);
    int unsigned n;
    n = 0;
    for (int unsigned t = v; t > 1; t = t >> 1) n++;
    return n;
  endfunction

endpackage

// File: rtl/const_div_ctl.sv
module const_div_ctl
  import const_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output divStrobe_t strobe,
  output logic       validOut
);

  logic stage1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      validOut    <= 1'b0;
    end else begin
      stage1Valid <= validIn;
      validOut    <= stage1Valid;
    end
  end

  always_comb begin
    strobe.loadEst = validIn;
    strobe.loadRes = stage1Valid;
  end

endmodule

// File: rtl/const_div_dp.sv
module const_div_dp
  import const_div_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int DIVISOR = 14,
  parameter int SHIFT   = 20,
  parameter int REM_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic [DATA_W-1:0] dividend,
  output logic [DATA_W-1:0] quotient,
  output logic [REM_W-1:0]  remainder
);

  localparam bit          POW2   = isPow2(DIVISOR);
  localparam int unsigned LOG2D  = log2Exact(DIVISOR);
  localparam int          PROD_W = DATA_W + SHIFT + 1;
  localparam int          WIDE_W = 2 * DATA_W;
  localparam logic [63:0] RECIP  = (64'd1 << SHIFT) / 64'(DIVISOR);
  localparam logic [DATA_W-1:0] DIV_C = DATA_W'(DIVISOR);

  logic [DATA_W-1:0] estNext;
  logic [DATA_W-1:0] estQ;
  logic [DATA_W-1:0] heldX;

  // Stage 1: first quotient estimate
  generate
    if (POW2) begin : g_shift
      assign estNext = dividend >> LOG2D;
    end else begin : g_mult
      logic [PROD_W-1:0] product;
      assign product = PROD_W'(dividend) * PROD_W'(RECIP);
      assign estNext = DATA_W'(product >> SHIFT);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      estQ  <= '0;
      heldX <= '0;
    end else if (strobe.loadEst) begin
      estQ  <= estNext;
      heldX <= dividend;
    end
  end

  // Stage 2: rebuild remainder and correct once
  logic [DATA_W-1:0] backProd;
  logic [DATA_W-1:0] rawRem;
  logic              needFix;
  logic [DATA_W-1:0] qNext;
  logic [DATA_W-1:0] rNext;

  always_comb begin
    backProd = DATA_W'(WIDE_W'(estQ) * WIDE_W'(DIV_C));
    rawRem   = heldX - backProd;
    needFix  = (rawRem >= DIV_C);
    qNext    = estQ + DATA_W'(needFix);
    rNext    = needFix ? (rawRem - DIV_C) : rawRem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
    end else if (strobe.loadRes) begin
      quotient  <= qNext;
      remainder <= REM_W'(rNext);
    end
  end

endmodule

// File: rtl/const_div_top.sv
module const_div_top
  import const_div_pkg::*;
#(
  parameter  int DATA_W  = 14,
  parameter  int DIVISOR = 14,
  parameter  int SHIFT   = 20,
  localparam int REM_W   = (DIVISOR > 1) ? $clog2(DIVISOR) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [DATA_W-1:0] dividend,
  output logic              validOut,
  output logic [DATA_W-1:0] quotient,
  output logic [REM_W-1:0]  remainder
);

  divStrobe_t strobe;

  const_div_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  const_div_dp #(
    .DATA_W  (DATA_W),
    .DIVISOR (DIVISOR),
    .SHIFT   (SHIFT),
    .REM_W   (REM_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dividend  (dividend),
    .quotient  (quotient),
    .remainder (remainder)
  );

endmodule

// File: rtl/const_div_chk.sv
module const_div_chk #(
  parameter int DATA_W  = 14,
  parameter int DIVISOR = 14,
  parameter int REM_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [DATA_W-1:0] dividend,
  input logic              validOut,
  input logic [DATA_W-1:0] quotient,
  input logic [REM_W-1:0]  remainder
);

  logic [DATA_W-1:0] shadow1;
  logic [DATA_W-1:0] shadow2;
  logic [63:0]       recombined;

  always_ff @(posedge clk) begin
    shadow1 <= dividend;
    shadow2 <= shadow1;
  end

  assign recombined = 64'(quotient) * 64'(DIVISOR) + 64'(remainder);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rstN |-> (!validOut && quotient == '0 && remainder == '0));

  // R4
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |-> ##2 validOut);

  // R4
  bubble_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |-> ##2 !validOut);

  // R3
  rem_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (64'(remainder) < 64'(DIVISOR)));

  // R2
  recombine_chk: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (recombined == 64'(shadow2)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind const_div_top const_div_chk #(
  .DATA_W  (DATA_W),
  .DIVISOR (DIVISOR),
  .REM_W   (REM_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .dividend  (dividend),
  .validOut  (validOut),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/const_div_top_tb_top.sv
module const_div_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        validIn;
  logic [13:0] dividend;
  logic        validOut;
  logic [13:0] quotient;
  logic [3:0]  remainder;
  logic        validOut8;
  logic [9:0]  quotient8;
  logic [2:0]  remainder8;

  always #5 clk = ~clk;

  const_div_top dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .dividend(dividend),
    .validOut(validOut), .quotient(quotient), .remainder(remainder)
  );

  const_div_top #(.DATA_W(10), .DIVISOR(8), .SHIFT(20)) dut8_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .dividend(dividend[9:0]),
    .validOut(validOut8), .quotient(quotient8), .remainder(remainder8)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        hv [2];
  logic [13:0] hd [2];
  int expQ, expR, expQ8, expR8;

  function automatic int refQuot(input int x, input int d);
    return x / d;
  endfunction

  function automatic int refRem(input int x, input int d);
    return x % d;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [13:0] d);
    @(negedge clk);
    if (hv[1]) begin
      expQ  = refQuot(int'(hd[1]), 14);
      expR  = refRem(int'(hd[1]), 14);
      expQ8 = refQuot(int'(hd[1][9:0]), 8);
      expR8 = refRem(int'(hd[1][9:0]), 8);
    end
    check("R4 validOut", int'(validOut), int'(hv[1]));
    if (hv[1]) begin
      check("R2/R6 quotient", int'(quotient), expQ);
      check("R3/R6 remainder", int'(remainder), expR);
    end else begin
      check("R5 held quotient", int'(quotient), expQ);
      check("R5 held remainder", int'(remainder), expR);
    end
    check("R7 validOut8", int'(validOut8), int'(hv[1]));
    check("R7 quotient8", int'(quotient8), expQ8);
    check("R7 remainder8", int'(remainder8), expR8);
    hv[1] = hv[0];
    hd[1] = hd[0];
    hv[0] = v;
    hd[0] = d;
    validIn  = v;
    dividend = d;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0;
    validIn = 1'b1;
    dividend = 14'd100;
    hv[0] = 1'b0; hv[1] = 1'b0; hd[0] = '0; hd[1] = '0;
    expQ = 0; expR = 0; expQ8 = 0; expR8 = 0;
    // R1: reset holds everything at zero even with validIn high
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 validOut", int'(validOut), 0);
      check("R1 quotient", int'(quotient), 0);
      check("R1 remainder", int'(remainder), 0);
    end
    validIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3 R6: every 14-bit operand back to back
    for (int i = 0; i < 16384; i++) step(1'b1, 14'(i));

    // R5: garbage with validIn low must not disturb held result
    for (int i = 0; i < 20; i++) step(1'b0, 14'($urandom));

    // Directed corners: top of range, around divisor, zero
    step(1'b1, 14'd16383);
    step(1'b0, 14'd5);
    step(1'b1, 14'd16380);
    step(1'b1, 14'd13);
    step(1'b1, 14'd14);
    step(1'b1, 14'd15);
    step(1'b0, 14'd9999);
    step(1'b0, 14'd1);
    step(1'b1, 14'd0);
    step(1'b1, 14'd28);

    // R4 R5: random traffic with gaps
    for (int i = 0; i < 3000; i++) step(($urandom % 4) != 0, 14'($urandom));

    for (int i = 0; i < 4; i++) step(1'b0, 14'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule